// File: doc/BRIEF.md
# Dual-Edge Additive Self-Test Accumulator

This block sits behind the capture stage of a double-data-rate bus and keeps two running sums: one over the words that arrived on the rising clock edge and one over the words that arrived on the falling edge. The capture stage has already split the bus into two 16-bit lanes, so the block receives both lanes on every clock. Software controls it through a single 8-bit control register. One bit starts and stops accumulation. Another bit copies the running sums into result registers. Clearing bit 5 after it has been set zeroes everything. Each result is read back as a low byte and a high byte.

A typical test runs as follows. Software clears the block, enables accumulation, and lets a known pseudo-random burst go through the bus. The source then sends zeros, and software issues a read command and reads the four result bytes. Because the sums are plain additions, the same burst always gives the same pair of sums, so a mismatch shows that the capture timing is wrong.

Top module: `bist_edge_checker`

## Requirements
- R1: After reset the control register, both running sums and both result registers are zero, and every register address reads back 0x00.
- R2: A write to address 0x1A stores the byte in the control register, and the stored byte reads back at 0x1A. A write to any other address changes nothing.
- R3: While control bit 7 is set, every clock adds the rising lane to the rising sum and the falling lane to the falling sum, starting with the clock after the control write. Each sum is 16 bits wide and wraps modulo 65536.
- R4: While control bit 7 is clear, both running sums hold their value whatever the lanes carry.
- R5: A control write with bit 5 clear, following a stored control byte with bit 5 set (for example 0x20 then 0x00), zeroes both running sums and both result registers one clock later. A clear takes priority over a read command issued in the same write.
- R6: A control write with bit 6 set (for example 0xC0) is a read command. One clock later it copies both running sums into the result registers. Outside a read command or a clear, the result registers hold their value.
- R7: The rising result reads at 0x1B (bits 7:0) and 0x1C (bits 15:8). The falling result reads at 0x1D (bits 7:0) and 0x1E (bits 15:8). Any address outside 0x1A to 0x1E reads 0x00. Reads are combinational from the read address.
- R8: Zero samples leave the sums unchanged. Sending the same sample sequence again after a clear gives identical sums.
- R9: The two lanes are independent: data on one lane never affects the other lane's sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock; both lanes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Read data for rd_addr |
| rise_data | input | 16 | Word captured on the rising edge of the bus clock |
| fall_data | input | 16 | Word captured on the falling edge of the bus clock |

## Verification
The assertions assume the following about the inputs:
- The lanes carry zeros around every read command, so the value latched does not depend on the one-clock gap between the write and the copy.
- The write port issues at most one write per clock and holds the strobe low during reset.

The stimulus keeps within these assumptions. Data is driven only in dedicated sample phases. Each register write is followed by an idle clock with both lanes held at zero. Random lane values, including runs of 0xFFFF that force wrap-around, appear only between writes.

// File: rtl/bist_edge_pkg.sv
package bist_edge_pkg;
    localparam int EN_BIT  = 7;
    localparam int RD_BIT  = 6;
    localparam int CLR_BIT = 5;
    localparam int LANES   = 2;

    typedef struct packed {
        logic add;
        logic clr;
        logic latch;
    } lane_cmd_t;
endpackage

// File: rtl/bist_ctrl.sv
module bist_ctrl
    import bist_edge_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                REG_W     = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h1A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  ctrl_q,
    output lane_cmd_t         cmd
);
    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic             clr;
        logic             latch;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.clr   = 1'b0;
        st_d.latch = 1'b0;
        if (wr_en && (wr_addr == CTRL_ADDR)) begin
            st_d.ctrl  = wr_data;
            st_d.clr   = st_q.ctrl[CLR_BIT] && !wr_data[CLR_BIT];
            st_d.latch = wr_data[RD_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_q    = st_q.ctrl;
    assign cmd.add   = st_q.ctrl[EN_BIT];
    assign cmd.clr   = st_q.clr;
    assign cmd.latch = st_q.latch;
endmodule

// File: rtl/edge_sum_lane.sv
module edge_sum_lane
    import bist_edge_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SUM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lane_cmd_t         cmd,
    input  logic [DATA_W-1:0] sample,
    output logic [SUM_W-1:0]  res_q
);
    typedef struct packed {
        logic [SUM_W-1:0] acc;
        logic [SUM_W-1:0] res;
    } lane_st_t;

    lane_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd.clr) begin
            st_d.acc = '0;
            st_d.res = '0;
        end else begin
            if (cmd.add)   st_d.acc = st_q.acc + SUM_W'(sample);
            if (cmd.latch) st_d.res = st_q.acc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_q = st_q.res;
endmodule

// File: rtl/bist_readmux.sv
module bist_readmux #(
    parameter int                ADDR_W    = 8,
    parameter int                REG_W     = 8,
    parameter int                SUM_W     = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h1A,
    parameter logic [ADDR_W-1:0] RISE_BASE = 8'h1B,
    parameter logic [ADDR_W-1:0] FALL_BASE = 8'h1D
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [REG_W-1:0]  ctrl,
    input  logic [SUM_W-1:0]  rise_res,
    input  logic [SUM_W-1:0]  fall_res,
    output logic [REG_W-1:0]  rd_data
);
    localparam int NBYTES = SUM_W / REG_W;

    always_comb begin
        rd_data = '0;
        if (rd_addr == CTRL_ADDR) rd_data = ctrl;
        for (int b = 0; b < NBYTES; b++) begin
            if (rd_addr == RISE_BASE + ADDR_W'(b)) rd_data = rise_res[b*REG_W +: REG_W];
            if (rd_addr == FALL_BASE + ADDR_W'(b)) rd_data = fall_res[b*REG_W +: REG_W];
        end
    end
endmodule

// File: rtl/bist_edge_checker.sv
module bist_edge_checker
    import bist_edge_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                REG_W     = 8,
    parameter int                DATA_W    = 16,
    parameter int                SUM_W     = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h1A,
    parameter logic [ADDR_W-1:0] RISE_BASE = 8'h1B,
    parameter logic [ADDR_W-1:0] FALL_BASE = 8'h1D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic [DATA_W-1:0] rise_data,
    input  logic [DATA_W-1:0] fall_data
);
    logic [REG_W-1:0]  ctrl_q;
    lane_cmd_t         cmd;
    logic [DATA_W-1:0] lane_in  [LANES];
    logic [SUM_W-1:0]  lane_res [LANES];
    logic [SUM_W-1:0]  rise_res, fall_res;

    bist_ctrl #(.ADDR_W(ADDR_W), .REG_W(REG_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl_q(ctrl_q), .cmd(cmd)
    );

    assign lane_in[0] = rise_data;
    assign lane_in[1] = fall_data;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        edge_sum_lane #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .cmd(cmd),
            .sample(lane_in[g]), .res_q(lane_res[g])
        );
    end

    assign rise_res = lane_res[0];
    assign fall_res = lane_res[1];

    bist_readmux #(
        .ADDR_W(ADDR_W), .REG_W(REG_W), .SUM_W(SUM_W),
        .CTRL_ADDR(CTRL_ADDR), .RISE_BASE(RISE_BASE), .FALL_BASE(FALL_BASE)
    ) u_rd (
        .rd_addr(rd_addr), .ctrl(ctrl_q), .rise_res(rise_res),
        .fall_res(fall_res), .rd_data(rd_data)
    );
endmodule

// File: rtl/bist_edge_checker_chk.sv
module bist_edge_checker_chk
    import bist_edge_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                REG_W     = 8,
    parameter int                SUM_W     = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h1A
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [REG_W-1:0]  wr_data,
    input logic [REG_W-1:0]  ctrl_q,
    input lane_cmd_t         cmd,
    input logic [SUM_W-1:0]  rise_res,
    input logic [SUM_W-1:0]  fall_res
);
    logic ctrl_wr;
    assign ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);

    // R2
    ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> ctrl_q == $past(wr_data));

    // R2
    ctrl_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(ctrl_q));

    // R5
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.clr |=> (rise_res == '0) && (fall_res == '0));

    // R5
    clear_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.clr |-> $past(ctrl_q[CLR_BIT]));

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd.clr && !cmd.latch) |=> ($stable(rise_res) && $stable(fall_res)));

    // R3
    enable_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd.add) |-> $past(ctrl_wr && wr_data[EN_BIT]));
endmodule

bind bist_edge_checker bist_edge_checker_chk #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .SUM_W(SUM_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_q(ctrl_q), .cmd(cmd),
    .rise_res(rise_res), .fall_res(fall_res)
);

// File: tb/bist_edge_checker_test.sv
module bist_edge_checker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [15:0] rise_data = '0;
    logic [15:0] fall_data = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0]  m_ctrl = '0;
    logic [15:0] m_racc = '0, m_facc = '0, m_rres = '0, m_fres = '0;
    logic [15:0] keep_r, keep_f;

    always #4 clk = ~clk;

    bist_edge_checker uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .rise_data(rise_data), .fall_data(fall_data)
    );

    function automatic logic [15:0] pat(int i, int lane);
        return 16'((i * 40503 + lane * 9973 + 7) ^ (i << 5));
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        rise_data = '0; fall_data = '0;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        if (a == 8'h1A) begin
            if (m_ctrl[5] && !d[5]) begin
                m_racc = '0; m_facc = '0; m_rres = '0; m_fres = '0;
            end else if (d[6]) begin
                m_rres = m_racc; m_fres = m_facc;
            end
            m_ctrl = d;
        end
    endtask

    task automatic drive(input logic [15:0] r, input logic [15:0] f);
        @(negedge clk);
        rise_data = r; fall_data = f;
        if (m_ctrl[7]) begin
            m_racc = m_racc + r; m_facc = m_facc + f;
        end
    endtask

    task automatic chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
        rd_addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            failures++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rd_data, exp);
        end
    endtask

    task automatic chk_res(input string tag);
        chk(8'h1B, m_rres[7:0],  tag);
        chk(8'h1C, m_rres[15:8], tag);
        chk(8'h1D, m_fres[7:0],  tag);
        chk(8'h1E, m_fres[15:8], tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        for (int a = 8'h1A; a <= 8'h1E; a++) chk(8'(a), 8'h00, "R1");

        // R2 stray write ignored, control write stored
        wr(8'h10, 8'h55);
        chk(8'h1A, 8'h00, "R2 ignored");
        chk(8'h19, 8'h00, "R7 unmapped");
        wr(8'h1A, 8'h20);
        chk(8'h1A, 8'h20, "R2 stored");
        wr(8'h1A, 8'h00);

        // R3 R9 random accumulation with wrap corner
        wr(8'h1A, 8'h80);
        for (int i = 0; i < 200; i++) drive(16'($urandom), 16'($urandom));
        for (int i = 0; i < 3; i++) drive(16'hFFFF, 16'h0000);
        for (int i = 0; i < 5; i++) drive(16'h0000, 16'h8001);
        drive('0, '0);
        wr(8'h1A, 8'hC0);
        chk_res("R3 R7 R9");
        chk(8'h1A, 8'hC0, "R2 readback");

        // R6 results hold while more data accumulates
        keep_r = m_rres; keep_f = m_fres;
        for (int i = 0; i < 40; i++) drive(16'($urandom), 16'($urandom));
        drive('0, '0);
        chk(8'h1B, keep_r[7:0], "R6 hold");
        chk(8'h1E, keep_f[15:8], "R6 hold");
        wr(8'h1A, 8'hC0);
        chk_res("R6 new read");

        // R4 disabled: data ignored
        wr(8'h1A, 8'h00);
        for (int i = 0; i < 50; i++) drive(16'($urandom), 16'($urandom));
        drive('0, '0);
        wr(8'h1A, 8'h40);
        chk_res("R4 disabled");

        // R5 clear sequence
        wr(8'h1A, 8'h20);
        wr(8'h1A, 8'h00);
        chk_res("R5 results zero");
        wr(8'h1A, 8'h40);
        chk_res("R5 sums zero");

        // R8 repeatability and zero samples
        wr(8'h1A, 8'h80);
        for (int i = 0; i < 64; i++) drive(pat(i, 0), pat(i, 1));
        for (int i = 0; i < 10; i++) drive('0, '0);
        wr(8'h1A, 8'hC0);
        keep_r = m_rres; keep_f = m_fres;
        chk_res("R8 first pass");
        wr(8'h1A, 8'h20);
        wr(8'h1A, 8'h00);
        wr(8'h1A, 8'h80);
        for (int i = 0; i < 64; i++) drive(pat(i, 0), pat(i, 1));
        for (int i = 0; i < 10; i++) drive('0, '0);
        wr(8'h1A, 8'hC0);
        chk(8'h1B, keep_r[7:0],  "R8 repeat");
        chk(8'h1C, keep_r[15:8], "R8 repeat");
        chk(8'h1D, keep_f[7:0],  "R8 repeat");
        chk(8'h1E, keep_f[15:8], "R8 repeat");

        // R9 only one lane active
        wr(8'h1A, 8'h20);
        wr(8'h1A, 8'h80);
        for (int i = 0; i < 20; i++) drive(16'($urandom), 16'h0000);
        drive('0, '0);
        wr(8'h1A, 8'hC0);
        chk_res("R9 lane isolation");
        chk(8'h1D, 8'h00, "R9 falling idle");

        // R5 clear beats read in the same write
        wr(8'h1A, 8'hA0);
        wr(8'h1A, 8'hC0);
        chk_res("R5 priority");
        chk(8'hFF, 8'h00, "R7 unmapped high");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule